// File: doc/BRIEF.md
# Finite Two-Phase Non-Overlapping Burst Clock Generator

This block produces a finite train of non-overlapping two-phase clock pulses, of the kind used to drive the switches of a switched-capacitor stage. It runs from one free-running clock. A single up-counter is cut into bit fields. The low field sets how wide a pulse is and how often pulses come. The next bit steers each pulse to phase 1 or phase 2. The remaining upper bits count how far the burst has gone. Every decision is an equality test on a fixed field value, so the logic between registers stays shallow.

When the counter reaches all ones it freezes and the block raises `done`. A `start` pulse given while `done` is high launches a fresh burst. An optional clock-enable prescaler slows the whole sequence by an integer ratio without widening the counter. Both phase outputs come straight from flip-flops, so the pins carry no decode glitches.

Top module: `burst_clk_gen`

## Requirements
- R1: A pulse is issued only while the low PW_BITS field of the count is zero. Each pulse therefore covers one count out of every 2^PW_BITS and lasts PRESCALE clock cycles.
- R2: Count bit PW_BITS picks the phase: value 0 sends the pulse to `phi1` and value 1 sends it to `phi2`, so the phases alternate pulse by pulse. A phase output shows the decode of the count held before each rising edge, one cycle after that count.
- R3: `phi1` and `phi2` are never high in the same cycle.
- R4: One burst gives exactly PULSES_PER_PHASE pulses on each phase (2*PULSES_PER_PHASE in all; 8 and 8 with the defaults). After that the count stops at all ones.
- R5: `done` goes high at the clock edge where the count becomes all ones. It stays high until a restart, and no pulse appears while it stays high.
- R6: `start` sampled high while `done` is high clears the count and the prescaler, drops `done` and runs a new burst whose timing matches a burst that follows reset. `start` sampled while a burst is running has no effect.
- R7: `rst` is synchronous and active high. While it is asserted the count is zero and `phi1`, `phi2` and `done` are low. A burst starts by itself once `rst` is released, and `phi1` is high after the first edge that samples `rst` low.
- R8: The count advances once every PRESCALE clock cycles, at the edges numbered PRESCALE, 2*PRESCALE and so on after reset or restart. With PRESCALE = 1 it advances on every edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running input clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Starts a new burst when `done` is high |
| phi1 | output | 1 | Phase-1 pulse output, registered |
| phi2 | output | 1 | Phase-2 pulse output, registered |
| done | output | 1 | Burst finished; the count is frozen |

## Verification
The assertions guard, on every cycle, the properties that hold at any moment:
- the two phases never overlap;
- `done` is sticky and the count is frozen while it is high;
- no pulse appears after `done` has settled;
- a running burst is never cleared by `start`;
- reset holds everything low.

Only the bench's scenarios can show the properties that depend on the whole sequence:
- the exact position of every pulse and the phase it lands on;
- the pulse total per phase;
- the edge at which `done` rises;
- that a restarted burst reproduces the timing seen after reset;
- that a non-unit prescale stretches each count by the right number of cycles.

// File: rtl/burst_clk_pkg.sv
package burst_clk_pkg;

  // Value of the steering bit that routes a pulse to each phase
  typedef enum logic {
    PH_ONE = 1'b0,
    PH_TWO = 1'b1
  } phase_e;

  // Counter width: pulse field, one steering bit, burst index field
  function automatic int cnt_width(input int pw_bits, input int per_phase);
    return pw_bits + 1 + $clog2(per_phase);
  endfunction

endpackage

// File: rtl/bc_prescaler.sv
module bc_prescaler #(
  parameter int PRESCALE = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int PSW = $clog2(PRESCALE > 1 ? PRESCALE : 2);
  localparam logic [PSW-1:0] LAST = PSW'(PRESCALE - 1);

  logic [PSW-1:0] pre_q;

  assign tick = (pre_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr || tick) pre_q <= '0;
    else                    pre_q <= pre_q + 1'b1;
  end

  // R8: the divider never runs past its last state
  p_pre_range_r8: assert property (@(posedge clk) disable iff (rst)
    (pre_q == LAST) |=> (pre_q == '0));

endmodule

// File: rtl/bc_seq_counter.sv
module bc_seq_counter #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          start,
  output logic [CW-1:0] cnt,
  output logic          done,
  output logic          restart
);
  localparam logic [CW-1:0] TERM    = '1;
  localparam logic [CW-1:0] TERM_M1 = TERM - 1'b1;

  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign restart = start && done_q;
  assign cnt     = cnt_q;
  assign done    = done_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (tick && !done_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == TERM_M1) done_q <= 1'b1;
    end
  end

  // R5: done holds until a restart
  p_done_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (done_q && !start) |=> done_q);

  // R5 / R4: the count stays frozen at terminal value
  p_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    (done_q && !start) |=> (cnt_q == TERM));

  // R6: a start during a running burst does not clear the count
  p_start_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (start && !done_q && cnt_q != '0) |=> (cnt_q != '0));

endmodule

// File: rtl/bc_phase_decode.sv
module bc_phase_decode
  import burst_clk_pkg::*;
#(
  parameter int PW_BITS = 3,
  parameter int CW      = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt,
  output logic [1:0]    phi
);
  logic   slot_zero;
  phase_e sel;

  assign slot_zero = (cnt[PW_BITS-1:0] == '0);
  assign sel       = phase_e'(cnt[PW_BITS]);

  // One registered decoder per phase
  for (genvar g = 0; g < 2; g++) begin : g_phase
    logic phi_q;
    always_ff @(posedge clk) begin
      if (rst) phi_q <= 1'b0;
      else     phi_q <= slot_zero && (sel == phase_e'(g));
    end
    assign phi[g] = phi_q;
  end

  // R3: phases never overlap
  p_no_overlap_r3: assert property (@(posedge clk) disable iff (rst)
    !(phi[0] && phi[1]));

endmodule

// File: rtl/burst_clk_gen.sv
module burst_clk_gen
  import burst_clk_pkg::*;
#(
  parameter int PW_BITS          = 3,
  parameter int PULSES_PER_PHASE = 8,
  parameter int PRESCALE         = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic phi1,
  output logic phi2,
  output logic done
);
  localparam int CW = cnt_width(PW_BITS, PULSES_PER_PHASE);

  logic          tick;
  logic          restart;
  logic [CW-1:0] cnt;
  logic [1:0]    phi;

  bc_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .clr  (restart),
    .tick (tick)
  );

  bc_seq_counter #(.CW(CW)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .start   (start),
    .cnt     (cnt),
    .done    (done),
    .restart (restart)
  );

  bc_phase_decode #(.PW_BITS(PW_BITS), .CW(CW)) u_dec (
    .clk (clk),
    .rst (rst),
    .cnt (cnt),
    .phi (phi)
  );

  assign phi1 = phi[0];
  assign phi2 = phi[1];

  // R5: no pulse once done has settled
  p_quiet_done_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(done) && done) |-> (!phi1 && !phi2));

  // R7: a reset cycle leaves every output low
  p_reset_low_r7: assert property (@(posedge clk)
    $past(rst) |-> (!phi1 && !phi2 && !done));

endmodule

// File: tb/burst_clk_gen_tb_top.sv
module burst_clk_gen_tb_top;
  localparam int TERM_A = 127;   // default: 7-bit count
  localparam int TERM_B = 31;    // PW 2, 4 per phase: 5-bit count

  logic clk = 0;
  logic rst = 1;
  logic start_a = 0;
  logic start_b = 0;
  logic phi1_a, phi2_a, done_a, phi1_b, phi2_b, done_b;
  int checks = 0;
  int fails = 0;
  int n1 = 0, n2 = 0, m1 = 0, m2 = 0;

  always #5 clk = ~clk;

  burst_clk_gen dut_i (
    .clk (clk), .rst (rst), .start (start_a),
    .phi1 (phi1_a), .phi2 (phi2_a), .done (done_a)
  );

  burst_clk_gen #(.PW_BITS(2), .PULSES_PER_PHASE(4), .PRESCALE(2)) dut_p (
    .clk (clk), .rst (rst), .start (start_b),
    .phi1 (phi1_b), .phi2 (phi2_b), .done (done_b)
  );

  // Expected {phi1, phi2, done} after edge k (k >= 1) of a burst
  function automatic logic [2:0] expv(input int k, input int p, input int pw, input int term);
    int c;
    logic lz;
    logic ph;
    c = (k - 1) / p;
    if (c > term) c = term;
    lz = ((c & ((1 << pw) - 1)) == 0);
    ph = ((c >> pw) & 1) == 1;
    return {lz && !ph, lz && ph, (k / p) >= term};
  endfunction

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp, input int k);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s k=%0d actual=%b expected=%b", req, k, act, exp);
    end
  endtask

  // Sample points of the default instance: {k, phi1, phi2, done}
  localparam logic [10:0] TBL [12] = '{
    {8'd1,   3'b100}, {8'd2,   3'b000}, {8'd8,   3'b000}, {8'd9,   3'b010},
    {8'd10,  3'b000}, {8'd17,  3'b100}, {8'd113, 3'b100}, {8'd121, 3'b010},
    {8'd122, 3'b000}, {8'd126, 3'b000}, {8'd127, 3'b001}, {8'd140, 3'b001}
  };

  // Run n edges of a burst. Start is poked on dut_i at edge poke.
  task automatic sweep(input int n, input int poke, input bit chk_b, input bit use_tbl);
    int ti = 0;
    for (int k = 1; k <= n; k++) begin
      @(posedge clk); #2;
      start_a = (k == poke);
      if (use_tbl && ti < 12 && TBL[ti][10:3] == k[7:0]) begin
        chk("R1/R2/R5 table", {phi1_a, phi2_a, done_a}, TBL[ti][2:0], k);
        ti++;
      end
      chk("R1/R2/R4/R5/R6 sweep", {phi1_a, phi2_a, done_a}, expv(k, 1, 3, TERM_A), k);
      if (phi1_a && phi2_a) chk("R3 overlap", 3'b110, 3'b000, k);
      n1 += int'(phi1_a);
      n2 += int'(phi2_a);
      if (chk_b) begin
        chk("R8 prescale", {phi1_b, phi2_b, done_b}, expv(k, 2, 2, TERM_B), k);
        m1 += int'(phi1_b);
        m2 += int'(phi2_b);
      end
    end
    start_a = 0;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R7: reset state
    chk("R7 reset a", {phi1_a, phi2_a, done_a}, 3'b000, 0);
    chk("R7 reset b", {phi1_b, phi2_b, done_b}, 3'b000, 0);
    rst = 0;
    sweep(140, 0, 1, 1);
    // R4: pulse totals per phase (the default instance has 1-cycle pulses)
    chk("R4 count a", {1'b0, n1 == 8, n2 == 8}, 3'b011, n1 * 100 + n2);
    chk("R4/R8 count b", {1'b0, m1 == 8, m2 == 8}, 3'b011, m1 * 100 + m2);
    // R6: restart from done; the start edge itself shows no pulse and done low
    start_a = 1;
    @(posedge clk); #2;
    start_a = 0;
    chk("R6 restart edge", {phi1_a, phi2_a, done_a}, 3'b000, 0);
    n1 = 0; n2 = 0;
    sweep(140, 0, 0, 1);
    chk("R6 restart count", {1'b0, n1 == 8, n2 == 8}, 3'b011, n1 * 100 + n2);
    // R7: reset during a burst, then R6: start while running is ignored
    rst = 1;
    repeat (2) @(posedge clk);
    #2;
    chk("R7 mid reset", {phi1_a, phi2_a, done_a}, 3'b000, 0);
    rst = 0;
    sweep(140, 20, 0, 0);
    // R6: done holds with no start (no pulse either, R5)
    repeat (5) @(posedge clk);
    #2;
    chk("R5 hold", {phi1_a, phi2_a, done_a}, 3'b001, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule